// File: doc/BRIEF.md
# Double-rate TMDS lane serializer

This block takes the three 10-bit TMDS-encoded colour words (blue, green, red) that a video encoder produces once per pixel clock and turns them into a bit stream. It runs from a fast clock at five times the pixel rate, for example 200 MHz for a 40 MHz pixel clock. On every fast cycle it hands two bits per lane to a double-data-rate output stage: one bit for the rising edge of the fast clock and one for the edge of its 180-degree copy. Ten bits therefore leave in one pixel period. A fourth lane carries a fixed pattern that repeats as the link clock.

The pixel clock is sampled in the fast domain. Its first rising edge after reset aligns a modulo-five phase counter. From then on the counter alone decides when a new word set is captured, and every later pixel edge must land on the counter's last phase. Each captured word is shifted right two places per fast cycle, so bit 0 leaves first.

Top module: `tmds_ddr_serializer`

## Requirements
- R1: While reset is asserted, and after reset until the first pixel clock rising edge has been captured, both pair outputs are all zero.
- R2: The words present on the three inputs are captured once per pixel period. The first pair of a word appears on the outputs after the second rising fast-clock edge that follows the pixel clock's rising edge.
- R3: Over the five fast cycles that follow a capture, pair j (j = 0..4) of a lane carries bit 2j on `pair_lo` (first DDR edge) and bit 2j+1 on `pair_hi` (second DDR edge), so bit 0 leaves first.
- R4: Lane positions within `pair_lo` and `pair_hi` are fixed: bit 0 is blue, bit 1 is green, bit 2 is red and bit 3 is the clock lane.
- R5: The clock lane sends 10'b0000011111 every pixel period: five ones (bits 0..4) followed by five zeros.
- R6: Changes on the word inputs between two captures have no effect on the word being sent.
- R7: Consecutive pixels are sent back to back with no gap or repeated pair. A capture never follows another capture on the next fast cycle, and once aligned every pixel edge falls on the last of the five phases.
- R8: The three colour lanes carry independent words with no crosstalk between lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Serial clock, five times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled in the fast domain |
| blue_word | input | 10 | TMDS word for the blue lane |
| green_word | input | 10 | TMDS word for the green lane |
| red_word | input | 10 | TMDS word for the red lane |
| pair_lo | output | 4 | Bit for the first DDR edge, one per lane |
| pair_hi | output | 4 | Bit for the second DDR edge, one per lane |

## Verification
The hardest case is showing that a word is captured exactly once and is not taken again from inputs that change in the middle of a pixel period. A design that re-captured continuously would still send the right words if the inputs were held steady. The stimulus therefore drives deliberately wrong values onto every word input at each falling pixel clock edge, and restores the intended word only at the next rising edge. Each lane is rebuilt from five consecutive pairs and compared with the word that was valid at that rising edge. Directed all-zeros, all-ones and alternating words expose bit-order and lane-order errors, and random words cover the rest.

// File: rtl/tmds_ddr_serializer.sv
module tmds_ddr_serializer #(
  parameter int WORD_W = 10,
  parameter logic [WORD_W-1:0] CLK_PATTERN = 10'b0000011111
) (
  input  logic              fast_clk,
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic [WORD_W-1:0] blue_word,
  input  logic [WORD_W-1:0] green_word,
  input  logic [WORD_W-1:0] red_word,
  output logic [3:0]        pair_lo,
  output logic [3:0]        pair_hi
);
  localparam int STEPS = WORD_W / 2;
  localparam int PW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [PW-1:0] LAST = PW'(STEPS - 1);

  logic pix_s1, pix_s2, locked, pix_rise, load;
  logic [PW-1:0] phase;
  logic [WORD_W-1:0] lane_sh [4];
  logic [WORD_W-1:0] lane_in [4];

  assign pix_rise = pix_s1 & ~pix_s2;
  assign load = locked ? (phase == LAST) : pix_rise;

  assign lane_in[0] = blue_word;
  assign lane_in[1] = green_word;
  assign lane_in[2] = red_word;
  assign lane_in[3] = CLK_PATTERN;

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_s1 <= 1'b0;
      pix_s2 <= 1'b0;
      locked <= 1'b0;
      phase  <= '0;
    end else begin
      pix_s1 <= pix_clk;
      pix_s2 <= pix_s1;
      if (pix_rise) locked <= 1'b1;
      if (pix_rise || phase == LAST) phase <= '0;
      else phase <= phase + 1'b1;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    always_ff @(posedge fast_clk or negedge rst_n) begin
      if (!rst_n) lane_sh[i] <= '0;
      else if (load) lane_sh[i] <= lane_in[i];
      else lane_sh[i] <= lane_sh[i] >> 2;
    end
    assign pair_lo[i] = lane_sh[i][0];
    assign pair_hi[i] = lane_sh[i][1];
  end

  // R1
  idle_zero_chk: assert property (@(posedge fast_clk)
    (!rst_n || !locked) |-> (pair_lo == 4'b0 && pair_hi == 4'b0));

  // R5
  clk_lane_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    load |=> (pair_lo[3] == CLK_PATTERN[0] && pair_hi[3] == CLK_PATTERN[1]));

  // R7
  no_back_to_back_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    load |=> !load);

  // R7
  edge_on_phase_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    (locked && pix_rise) |-> (phase == LAST));

  // R2
  capture_chk: assert property (@(posedge fast_clk) disable iff (!rst_n)
    load |=> (pair_lo[0] == $past(blue_word[0]) && pair_hi[2] == $past(red_word[1])));
endmodule

// File: tb/tmds_ddr_serializer_bench.sv
module tmds_ddr_serializer_bench;
  localparam int NPIX = 40;
  localparam logic [9:0] CLK_PAT = 10'b0000011111;

  logic fast_clk = 1'b0;
  logic pix_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] blue_word = '0, green_word = '0, red_word = '0;
  logic [3:0] pair_lo, pair_hi;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [9:0] wb [NPIX+2];
  logic [9:0] wg [NPIX+2];
  logic [9:0] wr [NPIX+2];

  tmds_ddr_serializer u_tmds_ddr_serializer (
    .fast_clk(fast_clk), .rst_n(rst_n), .pix_clk(pix_clk),
    .blue_word(blue_word), .green_word(green_word), .red_word(red_word),
    .pair_lo(pair_lo), .pair_hi(pair_hi));

  always #10 fast_clk = ~fast_clk;
  initial begin
    #11;
    forever begin pix_clk = 1'b1; #50; pix_clk = 1'b0; #50; end
  end

  function automatic logic [9:0] rebuild(input logic [4:0] lo, input logic [4:0] hi);
    logic [9:0] w;
    for (int j = 0; j < 5; j++) begin
      w[2*j] = lo[j];
      w[2*j+1] = hi[j];
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %03h expected %03h", req, act, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    wb[0] = 10'h000; wg[0] = 10'h3FF; wr[0] = 10'h2AA;
    wb[1] = 10'h3FF; wg[1] = 10'h155; wr[1] = 10'h000;
    wb[2] = 10'h001; wg[2] = 10'h200; wr[2] = 10'h3FE;
    wb[3] = 10'h2AA; wg[3] = 10'h2AA; wr[3] = 10'h155;
    for (int n = 4; n < NPIX + 2; n++) begin
      wb[n] = 10'($urandom); wg[n] = 10'($urandom); wr[n] = 10'($urandom);
    end
  end

  initial begin
    #55;
    check("R1 reset lo", {6'b0, pair_lo}, 10'h0);
    check("R1 reset hi", {6'b0, pair_hi}, 10'h0);
    #150;
    rst_n = 1'b1;
    #20;
    check("R1 before first edge", {2'b0, pair_hi, pair_lo}, 10'h0);
    fork
      begin
        for (int n = 0; n < NPIX + 2; n++) begin
          @(posedge pix_clk);
          blue_word = wb[n]; green_word = wg[n]; red_word = wr[n];
          @(negedge pix_clk);
          // R6: junk between captures
          blue_word = ~wb[n]; green_word = 10'($urandom); red_word = wr[n] ^ 10'h3C3;
        end
      end
      begin
        logic [4:0] lo [4];
        logic [4:0] hi [4];
        @(posedge pix_clk);
        repeat (2) @(posedge fast_clk);
        for (int n = 0; n < NPIX; n++) begin
          for (int j = 0; j < 5; j++) begin
            @(negedge fast_clk);
            for (int l = 0; l < 4; l++) begin
              lo[l][j] = pair_lo[l];
              hi[l][j] = pair_hi[l];
            end
          end
          check("R3 R4 R6 R8 blue lane", rebuild(lo[0], hi[0]), wb[n]);
          check("R2 R4 R7 green lane", rebuild(lo[1], hi[1]), wg[n]);
          check("R3 R4 R8 red lane", rebuild(lo[2], hi[2]), wr[n]);
          check("R5 clock lane", rebuild(lo[3], hi[3]), CLK_PAT);
        end
      end
    join
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule